// File: doc/BRIEF.md
# Wrapping Burst Fetch Assembler

This block gathers 16-bit words returned by a fast memory read port into one wide fetch word for a slower consumer. Memory returns words in wrap-within-group order: the first word comes from the requested offset, and each later word comes from the next offset modulo the group size. For example, a start of 3 in a group of four visits offsets 3, 0, 1, 2. The block writes each arriving word into the lane that matches its wrapped offset, so the result does not depend on arrival order. Lanes that the fetch does not read are zero. The block also reports which offset the next word will fill.

A request carries the low word-address bits and one of four fetch modes. The mode sets how many beats are collected: one word, two words in either of two 32-bit forms, or the whole group. The block runs on the fast clock and produces a chipset-rate strobe on one fast cycle in every four. A finished fetch is presented with a valid flag for one full strobe period. A 32-bit fetch that starts on the last offset of a group cannot move on to the next group, because the second word would wrap back to offset 0. The block flags that fetch as misaligned.

Top module: `burst_fetch_asm`

## Requirements
- R1: While reset is held and right after it is released, fetch_valid, fetch_err and busy are 0 and fetch_data is all zero.
- R2: slow_ce is high on exactly one fast cycle in every four and is never high on two consecutive cycles.
- R3: During a burst, beat_off gives the lane that the next accepted beat fills. It starts at req_off and advances by one, modulo 4, for each beat taken.
- R4: A beat with offset o is stored in fetch_data bits [16*o+15:16*o]. Lanes the fetch does not read are zero.
- R5: Mode 2'b00 (one word) collects a single beat into lane req_off. fetch_valid rises on the clock edge that takes that beat.
- R6: Modes 2'b01 and 2'b10 (32-bit) collect two beats. Mode 2'b11 (full group) collects four beats. fetch_valid rises on the edge that takes the last beat.
- R7: fetch_err is high together with fetch_valid when the mode is 2'b01 or 2'b10 and req_off is 3. It is low for every other mode and offset, including mode 2'b11 at offset 3.
- R8: fetch_valid stays high for exactly four consecutive fast cycles, and fetch_data does not change while it is high.
- R9: A request is accepted only when busy is low. busy stays high from acceptance until fetch_valid drops. A req pulse while busy is high, or an sd_valid beat while no burst is active, has no effect on the data or on the number of results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Fetch request, accepted when busy is low |
| req_off | input | 2 | Start word offset inside the group of four |
| req_mode | input | 2 | 00 one word, 01 32-bit single access, 10 32-bit two accesses, 11 full group |
| sd_valid | input | 1 | A returned memory word is present |
| sd_data | input | 16 | Returned memory word |
| busy | output | 1 | A burst or a held result is in progress |
| beat_off | output | 2 | Lane that the next beat fills |
| slow_ce | output | 1 | Chipset-rate strobe |
| fetch_data | output | 64 | Assembled fetch word |
| fetch_valid | output | 1 | Assembled word present, held for one strobe period |
| fetch_err | output | 1 | 32-bit fetch wrapped across a group boundary |

## Verification
Full-group fetches are run from all four start offsets. Each word carries a distinct value, so lane placement by wrapped offset can be told apart from placement by arrival order. Single-word fetches at every offset show that beat counting matches the mode and that unread lanes stay zero. The 32-bit modes are run at offsets that stay inside the group and at offset 3, which separates correct misalignment flagging from a rule that flags by offset alone. A req pulse during a burst and a stray beat while idle check that neither adds a result nor changes the data.

// File: rtl/fetch_asm_pkg.sv
package fetch_asm_pkg;

   typedef enum logic [1:0] {
      FM_ONE_WORD = 2'b00,
      FM_HALF_ONE = 2'b01,
      FM_HALF_TWO = 2'b10,
      FM_FULL     = 2'b11
   } fetch_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'b00,
      ST_BURST = 2'b01,
      ST_HOLD  = 2'b10
   } asm_state_e;

   function automatic int beats_for(input fetch_mode_e m, input int lanes);
      case (m)
         FM_ONE_WORD: return 1;
         FM_HALF_ONE,
         FM_HALF_TWO: return 2;
         default:     return lanes;
      endcase
   endfunction

endpackage

// File: rtl/fa_strobe_gen.sv
module fa_strobe_gen #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic strobe
);
   localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

   logic [CW-1:0] phase_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                       phase_q <= '0;
      else if (phase_q == CW'(DIV - 1)) phase_q <= '0;
      else                              phase_q <= phase_q + 1'b1;
   end

   assign strobe = (phase_q == CW'(DIV - 1));

   // R2: strobe never on two consecutive cycles
   p_strobe_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |=> !strobe);

endmodule

// File: rtl/fa_lane_store.sv
module fa_lane_store #(
   parameter int LANES  = 4,
   parameter int WORD_W = 16
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      clear,
   input  logic                      wr_en,
   input  logic [$clog2(LANES)-1:0]  wr_lane,
   input  logic [WORD_W-1:0]         wr_data,
   output logic [LANES*WORD_W-1:0]   word
);
   localparam int OFF_W = $clog2(LANES);

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [WORD_W-1:0] lane_q;
      always_ff @(posedge clk) begin
         if (!rst_n || clear)                       lane_q <= '0;
         else if (wr_en && wr_lane == OFF_W'(g))    lane_q <= wr_data;
      end
      assign word[g*WORD_W +: WORD_W] = lane_q;
   end

endmodule

// File: rtl/fa_burst_ctrl.sv
module fa_burst_ctrl
   import fetch_asm_pkg::*;
#(
   parameter int LANES  = 4,
   parameter int CE_DIV = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        req,
   input  logic [$clog2(LANES)-1:0]    req_off,
   input  logic [$clog2(LANES):0]      req_need,
   input  logic                        sd_valid,
   output logic                        busy,
   output logic [$clog2(LANES)-1:0]    beat_off,
   output logic                        clear,
   output logic                        wr_en,
   output logic                        fetch_valid,
   output logic                        fetch_err
);
   localparam int OFF_W  = $clog2(LANES);
   localparam int CNT_W  = OFF_W + 1;
   localparam int HOLD_W = $clog2(CE_DIV);

   asm_state_e        st_q;
   logic [OFF_W-1:0]  start_q;
   logic [CNT_W-1:0]  cnt_q, need_q;
   logic [HOLD_W-1:0] hold_q;
   logic              vld_q, err_q;
   logic [CNT_W:0]    span;
   logic              wraps, last;

   assign span     = {{(CNT_W + 1 - OFF_W){1'b0}}, req_off} + {1'b0, req_need};
   assign wraps    = (req_need < CNT_W'(LANES)) && (span > (CNT_W + 1)'(LANES));
   assign clear    = req && (st_q == ST_IDLE);
   assign wr_en    = sd_valid && (st_q == ST_BURST);
   assign last     = wr_en && ((cnt_q + 1'b1) == need_q);
   assign beat_off = start_q + cnt_q[OFF_W-1:0];
   assign busy     = (st_q != ST_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         start_q <= '0;
         cnt_q   <= '0;
         need_q  <= '0;
         hold_q  <= '0;
         vld_q   <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         case (st_q)
            ST_IDLE: if (req) begin
               start_q <= req_off;
               need_q  <= req_need;
               cnt_q   <= '0;
               err_q   <= wraps;
               st_q    <= ST_BURST;
            end
            ST_BURST: if (wr_en) begin
               cnt_q <= cnt_q + 1'b1;
               if (last) begin
                  st_q   <= ST_HOLD;
                  hold_q <= '0;
                  vld_q  <= 1'b1;
               end
            end
            default: begin
               hold_q <= hold_q + 1'b1;
               if (hold_q == HOLD_W'(CE_DIV - 1)) begin
                  vld_q <= 1'b0;
                  st_q  <= ST_IDLE;
               end
            end
         endcase
      end
   end

   assign fetch_valid = vld_q;
   assign fetch_err   = vld_q && err_q;

   // R3: each non-final beat moves the reported offset on by one, wrapping
   p_off_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !last) |=> (beat_off == $past(beat_off) + OFF_W'(1)));

endmodule

// File: rtl/burst_fetch_asm.sv
module burst_fetch_asm
   import fetch_asm_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int LANES  = 4,
   parameter int CE_DIV = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      req,
   input  logic [$clog2(LANES)-1:0]  req_off,
   input  logic [1:0]                req_mode,
   input  logic                      sd_valid,
   input  logic [WORD_W-1:0]         sd_data,
   output logic                      busy,
   output logic [$clog2(LANES)-1:0]  beat_off,
   output logic                      slow_ce,
   output logic [LANES*WORD_W-1:0]   fetch_data,
   output logic                      fetch_valid,
   output logic                      fetch_err
);
   localparam int OFF_W = $clog2(LANES);
   localparam int CNT_W = OFF_W + 1;

   if (LANES < 2 || LANES != (1 << OFF_W)) begin : g_bad_lanes
      $error("LANES must be a power of two of at least 2");
   end
   if (CE_DIV < 2 || CE_DIV != (1 << $clog2(CE_DIV))) begin : g_bad_div
      $error("CE_DIV must be a power of two of at least 2");
   end
   if (WORD_W < 1) begin : g_bad_word
      $error("WORD_W must be positive");
   end

   logic [CNT_W-1:0] need;
   logic             clear, wr_en;

   assign need = CNT_W'(beats_for(fetch_mode_e'(req_mode), LANES));

   fa_strobe_gen #(.DIV(CE_DIV)) u_strobe (
      .clk(clk), .rst_n(rst_n), .strobe(slow_ce));

   fa_burst_ctrl #(.LANES(LANES), .CE_DIV(CE_DIV)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .req(req), .req_off(req_off), .req_need(need),
      .sd_valid(sd_valid), .busy(busy), .beat_off(beat_off), .clear(clear),
      .wr_en(wr_en), .fetch_valid(fetch_valid), .fetch_err(fetch_err));

   fa_lane_store #(.LANES(LANES), .WORD_W(WORD_W)) u_store (
      .clk(clk), .rst_n(rst_n), .clear(clear), .wr_en(wr_en),
      .wr_lane(beat_off), .wr_data(sd_data), .word(fetch_data));

   // R5/R6: a result only appears on the edge that took a beat
   p_rise_on_beat_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fetch_valid) |-> $past(sd_valid));

   // R8: assembled word holds still while presented
   p_data_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_valid && $past(fetch_valid)) |-> $stable(fetch_data));

   // R8: valid drops only after four cycles high
   p_valid_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fetch_valid) |-> ($past(fetch_valid, 2) && $past(fetch_valid, 4)));

   // R9: a presented result keeps the block busy
   p_busy_cover_r9: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_valid |-> busy);

endmodule

// File: tb/tb_burst_fetch_asm.sv
`timescale 1ns/1ps
module tb_burst_fetch_asm;

   logic        clk = 0;
   logic        rst_n = 0;
   logic        req = 0;
   logic [1:0]  req_off = 0;
   logic [1:0]  req_mode = 0;
   logic        sd_valid = 0;
   logic [15:0] sd_data = 0;
   logic        busy, slow_ce, fetch_valid, fetch_err;
   logic [1:0]  beat_off;
   logic [63:0] fetch_data;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   typedef struct { logic [63:0] d; logic e; } exp_t;
   exp_t q[$];

   always #10 clk = ~clk;

   burst_fetch_asm dut (
      .clk(clk), .rst_n(rst_n), .req(req), .req_off(req_off), .req_mode(req_mode),
      .sd_valid(sd_valid), .sd_data(sd_data), .busy(busy), .beat_off(beat_off),
      .slow_ce(slow_ce), .fetch_data(fetch_data), .fetch_valid(fetch_valid),
      .fetch_err(fetch_err));

   task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic run_fetch(input logic [1:0] s, input logic [1:0] m,
                            input logic [15:0] base, input bit poke);
      int   need;
      exp_t x;
      need = (m == 2'b00) ? 1 : (m == 2'b11) ? 4 : 2;
      x.d = '0;
      for (int k = 0; k < need; k++) begin
         logic [1:0] o;
         o = s + 2'(k);
         x.d[16*o +: 16] = base + 16'(k);
      end
      x.e = (m == 2'b01 || m == 2'b10) && (s == 2'd3);
      q.push_back(x);
      @(negedge clk);
      req = 1; req_off = s; req_mode = m;
      @(negedge clk);
      req = 0;
      chk(busy == 1'b1, "R9 busy after accept", 64'(busy), 64'd1);
      for (int k = 0; k < need; k++) begin
         logic [1:0] eo;
         eo = s + 2'(k);
         chk(beat_off == eo, "R3 beat offset", 64'(beat_off), 64'(eo));
         sd_valid = 1; sd_data = base + 16'(k);
         if (poke && k == 0) begin
            req = 1; req_off = s + 2'd1; req_mode = 2'b11;
         end
         @(negedge clk);
         req = 0;
      end
      sd_valid = 0;
      while (busy) @(negedge clk);
   endtask

   // monitor: pops expected results as the design presents them
   logic        prev_v = 0;
   int          run = 0;
   logic [63:0] held = '0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (fetch_valid && !prev_v) begin
            if (q.size() == 0) begin
               chk(1'b0, "R9 unexpected result", fetch_data, 64'd0);
            end else begin
               exp_t x;
               x = q.pop_front();
               chk(fetch_data == x.d, "R4/R5/R6 assembled data", fetch_data, x.d);
               chk(fetch_err == x.e, "R7 misalign flag", 64'(fetch_err), 64'(x.e));
            end
            run = 1;
            held = fetch_data;
         end else if (fetch_valid) begin
            run++;
            chk(fetch_data == held, "R8 data stable", fetch_data, held);
         end else if (prev_v) begin
            chk(run == 4, "R8 valid length", 64'(run), 64'd4);
         end
         prev_v = fetch_valid;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int ce_cnt;
      bit ce_prev;
      repeat (3) @(negedge clk);
      // R1 during reset
      chk(!fetch_valid && !fetch_err && !busy && fetch_data == 0, "R1 reset state",
          fetch_data, 64'd0);
      rst_n = 1;
      @(negedge clk);
      chk(!fetch_valid && !busy, "R1 after release", 64'(busy), 64'd0);

      // R2 strobe rate
      ce_cnt = 0; ce_prev = 0;
      for (int i = 0; i < 40; i++) begin
         if (slow_ce) ce_cnt++;
         if (slow_ce && ce_prev) chk(1'b0, "R2 back-to-back strobe", 64'd1, 64'd0);
         ce_prev = slow_ce;
         @(negedge clk);
      end
      chk(ce_cnt == 10, "R2 strobe count", 64'(ce_cnt), 64'd10);

      // R4/R6 full group from every start offset
      for (int s = 0; s < 4; s++) run_fetch(2'(s), 2'b11, 16'hA000 + 16'(s*16), 0);
      // R5 single word at every offset
      for (int s = 0; s < 4; s++) run_fetch(2'(s), 2'b00, 16'hB000 + 16'(s*16), 0);
      // R7 32-bit modes inside and across the group edge
      run_fetch(2'd1, 2'b01, 16'hC100, 0);
      run_fetch(2'd3, 2'b01, 16'hC300, 0);
      run_fetch(2'd0, 2'b10, 16'hD000, 0);
      run_fetch(2'd3, 2'b10, 16'hD300, 0);
      run_fetch(2'd2, 2'b10, 16'hD200, 0);

      // R9 req while busy has no effect
      run_fetch(2'd1, 2'b11, 16'hE000, 1);

      // R9 stray beat while idle is ignored
      @(negedge clk);
      sd_valid = 1; sd_data = 16'hDEAD;
      @(negedge clk);
      sd_valid = 0;
      chk(!busy && !fetch_valid, "R9 idle beat ignored", 64'(busy), 64'd0);
      run_fetch(2'd2, 2'b00, 16'hF000, 0);

      repeat (8) @(negedge clk);
      chk(q.size() == 0, "R9 all results seen", 64'(q.size()), 64'd0);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule